// File: doc/BRIEF.md
# Preloadable Timer/Event Counter

This block is an 8-bit up-counter with a reload value and a control byte, all reached through a small register port. It has three counting sources. In timer mode it counts the internal clock, divided by a selectable power-of-two prescaler. In event mode it counts one chosen edge of an external pin. In pulse-width mode it counts prescaled clocks while that pin sits at a chosen level. The pin passes through a two-flop synchronizer before any edge or level is taken from it.

When the counter passes all ones, it wraps to the reload value and raises a one-cycle interrupt pulse. Firmware sets the period by choosing the reload value. A reload value of zero gives the full 256-count span. Writing the reload value while the counter is stopped also places it in the counter at once. While the counter runs, a new reload value waits for the next wrap. In pulse-width mode the block clears its own run bit when the measured pulse ends, so software can read the frozen width.

Top module: `tmr_event_core`

## Requirements
- R1: After reset the counter, reload and control registers all read 0x00 and `irq` is low.
- R2: Address 0 reads the counter, and writes to it are ignored. Address 1 reads and writes the reload register. Address 2 reads and writes the control byte. Address 3 reads 0x00, and writes to it are ignored. Read data is combinational on the address.
- R3: The control byte holds the mode in bits 7:6, the run bit in bit 4, the edge/level select in bit 3 and the prescale exponent N in bits 2:0. With mode 10 (timer) and run set, the counter advances once every 2^N clocks. The prescaler restarts from zero whenever the block is not counting prescaled clocks, so the first step comes on the 2^N-th rising edge after the run bit is written.
- R4: An increment applied at 0xFF loads the reload value instead, and `irq` is high for the one cycle in which the reloaded value is first visible.
- R5: A write to the reload register while the run bit is 0 also loads the counter. The new value reads back from address 0 one cycle later.
- R6: A write to the reload register while the run bit is 1 leaves the counter unchanged. The counter takes the new value at the next wrap.
- R7: In mode 01 (event) the counter advances on each rising edge of the synchronized pin when bit 3 is 0, and on each falling edge when bit 3 is 1. The step shows on the third rising clock edge after the pin changes. The prescale field has no effect in this mode.
- R8: In mode 11 (pulse width) the counter advances on prescaled ticks only while the synchronized pin is high (bit 3 = 0) or low (bit 3 = 1). When the pin leaves that active level, the hardware clears the run bit and counting stops.
- R9: With the run bit 0, or with mode 00, the counter holds its value apart from R5 loads.
- R10: A control write in the same cycle as a pulse-end clear takes priority, so the written byte is what reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 counter, 1 reload, 2 control |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| tmr_pin | input | 1 | Asynchronous external count/gate pin |
| irq | output | 1 | One-cycle wrap pulse |

## Verification
Register writes take effect on the rising edge that samples the strobe, so the counter, reload and control values are due one cycle after the write. A wrap shows up in the same cycle as the `irq` pulse. A pin change reaches the counter three clock edges later: two synchronizer stages plus the count register. A pulse end clears the run bit on the same third edge. A behavioural model in the bench steps once per rising edge from the same inputs and is compared 3 ns after each edge, well before the inputs move at the falling edge. The directed checks wait exactly these latencies, counted in falling edges, before they sample.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } tmr_mode_e;

  localparam logic [1:0] ADDR_COUNT  = 2'd0;
  localparam logic [1:0] ADDR_RELOAD = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;

  localparam int CTRL_MODE_HI = 7;
  localparam int CTRL_MODE_LO = 6;
  localparam int CTRL_RUN     = 4;
  localparam int CTRL_EDGE    = 3;
  localparam int CTRL_PS_HI   = 2;
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q, sh_d;
  logic              prev_q;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign rise_o = sh_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sh_q[STAGES-1] & prev_q;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int PS_W = (1 << SEL_W) - 1;

  logic [PS_W-1:0] div_q, div_d, mask;

  always_comb begin
    mask   = PS_W'((PS_W+1)'(1) << sel_i) - PS_W'(1);
    tick_o = en_i && ((div_q & mask) == mask);
    div_d  = en_i ? div_q + PS_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/tmr_count_unit.sv
module tmr_count_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_en_i,
  input  logic [W-1:0] reload_val_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    wrap_o = inc_en_i && (&cnt_q);
    cnt_en = load_en_i || inc_en_i;
    cnt_d  = cnt_q;
    if (load_en_i)   cnt_d = load_val_i;
    else if (wrap_o) cnt_d = reload_val_i;
    else             cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_event_core.sv
module tmr_event_core
  import tmr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PS_SEL_W    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tmr_pin,
  output logic              irq
);
  logic [DATA_W-1:0] ctrl_q, ctrl_d, pre_q, pre_d, cnt_q;
  logic              irq_q, wrap;
  logic              ctrl_wr, pre_wr, ctrl_en;
  logic              pin_lvl, pin_rise, pin_fall;
  logic              ps_en, ps_tick;
  logic              run, edge_sel, active, sel_edge, pulse_end, inc;
  tmr_mode_e         mode;

  assign mode     = tmr_mode_e'(ctrl_q[CTRL_MODE_HI:CTRL_MODE_LO]);
  assign run      = ctrl_q[CTRL_RUN];
  assign edge_sel = ctrl_q[CTRL_EDGE];
  assign ctrl_wr  = reg_wr && (reg_addr == ADDR_CTRL);
  assign pre_wr   = reg_wr && (reg_addr == ADDR_RELOAD);

  tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(tmr_pin),
    .lvl_o(pin_lvl), .rise_o(pin_rise), .fall_o(pin_fall)
  );

  assign ps_en = run && (mode == MODE_TIMER || mode == MODE_PULSE);

  tmr_prescaler #(.SEL_W(PS_SEL_W)) u_ps (
    .clk(clk), .rst_n(rst_n), .en_i(ps_en),
    .sel_i(ctrl_q[PS_SEL_W-1:0]), .tick_o(ps_tick)
  );

  always_comb begin
    sel_edge  = edge_sel ? pin_fall : pin_rise;
    active    = edge_sel ? ~pin_lvl : pin_lvl;
    pulse_end = run && (mode == MODE_PULSE) && (edge_sel ? pin_rise : pin_fall);
    inc       = 1'b0;
    if (run) begin
      unique case (mode)
        MODE_EVENT: inc = sel_edge;
        MODE_TIMER: inc = ps_tick;
        MODE_PULSE: inc = ps_tick && active;
        default:    inc = 1'b0;
      endcase
    end
  end

  tmr_count_unit #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .load_en_i(pre_wr && !run), .load_val_i(reg_wdata),
    .inc_en_i(inc), .reload_val_i(pre_q),
    .cnt_o(cnt_q), .wrap_o(wrap)
  );

  always_comb begin
    ctrl_en = ctrl_wr || pulse_end;
    ctrl_d  = ctrl_q;
    if (ctrl_wr)        ctrl_d = reg_wdata;
    else if (pulse_end) ctrl_d[CTRL_RUN] = 1'b0;
    pre_d = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pre_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (pre_wr)  pre_q  <= pre_d;
      irq_q <= wrap;
    end
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_COUNT:  reg_rdata = cnt_q;
      ADDR_RELOAD: reg_rdata = pre_q;
      ADDR_CTRL:   reg_rdata = ctrl_q;
      default:     reg_rdata = '0;
    endcase
  end

  assign irq = irq_q;
endmodule

// File: rtl/tmr_event_core_chk.sv
module tmr_event_core_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] cnt,
  input logic [W-1:0] pre,
  input logic         run,
  input logic         wr_pre,
  input logic [W-1:0] wdata,
  input logic         irq
);
  // R4: a wrap happens only from all ones
  p_wrap_from_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(cnt) == {W{1'b1}});

  // R4: the value after a wrap is the reload value held before it
  p_wrap_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cnt == $past(pre));

  // R3: apart from loads and wraps, the counter moves by exactly one
  p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) && !$past(wr_pre) && !irq |-> cnt == W'($past(cnt) + 1'b1));

  // R5: reload write while stopped lands in the counter
  p_stopped_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_pre && !run) |-> cnt == $past(wdata));

  // R9: stopped counter holds
  p_stopped_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run && !wr_pre) |-> cnt == $past(cnt));

  // R6: a running counter never jumps to the written reload value at the write
  p_running_defer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_pre && run) && !irq && (cnt != $past(cnt)) |-> cnt == W'($past(cnt) + 1'b1));
endmodule

bind tmr_event_core tmr_event_core_chk #(.W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .pre(pre_q), .run(ctrl_q[4]),
  .wr_pre(pre_wr), .wdata(reg_wdata), .irq(irq)
);

// File: tb/tb_tmr_event_core.sv
module tb_tmr_event_core;
  logic       clk, rst_n, reg_wr, tmr_pin, irq;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  tmr_event_core dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_pin(tmr_pin), .irq(irq)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // behavioural reference model
  int m_cnt, m_pre, m_ctrl, m_pc;
  bit m_irq;
  bit pin_hist[$];

  function automatic int m_read(input int a);
    case (a)
      0: return m_cnt;
      1: return m_pre;
      2: return m_ctrl;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_ctrl = 0; m_pc = 0; m_irq = 0;
      pin_hist = '{0, 0, 0};
    end else begin
      int  mode, n, ncnt, nctrl;
      bit  run, eb, lvl, rise, fall, ps_on, tick, inc, pend, wr_pre, wr_ctl;
      mode  = (m_ctrl >> 6) & 3;
      run   = m_ctrl[4];
      eb    = m_ctrl[3];
      n     = m_ctrl & 7;
      lvl   = pin_hist[1];
      rise  = pin_hist[1] && !pin_hist[2];
      fall  = !pin_hist[1] && pin_hist[2];
      ps_on = run && (mode == 2 || mode == 3);
      tick  = ps_on && ((m_pc % (1 << n)) == (1 << n) - 1);
      inc   = run && ((mode == 1 && (eb ? fall : rise)) || (mode == 2 && tick) ||
                      (mode == 3 && tick && (eb ? !lvl : lvl)));
      pend  = run && mode == 3 && (eb ? rise : fall);
      wr_pre = reg_wr && reg_addr == 1;
      wr_ctl = reg_wr && reg_addr == 2;
      ncnt  = m_cnt;
      m_irq = 0;
      if (wr_pre && !run) ncnt = reg_wdata;
      else if (inc) begin
        if (m_cnt == 255) begin ncnt = m_pre; m_irq = 1; end
        else ncnt = m_cnt + 1;
      end
      nctrl = m_ctrl;
      if (wr_ctl) nctrl = reg_wdata;
      else if (pend) nctrl = m_ctrl & ~32'h10;
      if (wr_pre) m_pre = reg_wdata;
      m_cnt  = ncnt;
      m_ctrl = nctrl;
      m_pc   = ps_on ? (m_pc + 1) % 128 : 0;
      pin_hist.push_front(tmr_pin);
      void'(pin_hist.pop_back());
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, 3 ns after each rising edge
  always begin
    @(posedge clk);
    #3;
    if (rst_n && !done) begin
      check("R4 irq compare", irq, m_irq);
      check("R1/R2 read compare", reg_rdata, m_read(reg_addr));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2000000;
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int v, c0;
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0; tmr_pin = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 3; a++) begin rd(a[1:0], v); check("R1 reset read", v, 0); end
    check("R1 irq low", irq, 0);

    // R2 counter and address 3 writes ignored
    wr(2'd0, 8'h55); rd(2'd0, v); check("R2 count write ignored", v, 0);
    wr(2'd3, 8'hAA); rd(2'd3, v); check("R2 addr3 reads zero", v, 0);

    // R5 stopped reload write loads counter
    wr(2'd1, 8'hFD); rd(2'd0, v); check("R5 stopped load", v, 8'hFD);

    // R4 overflow timing in timer mode 1:1
    wr(2'd2, 8'h90);
    reg_addr = 0;
    wait_cyc(2); rd(2'd0, v); check("R3 timer step", v, 8'hFF); check("R4 no irq yet", irq, 0);
    wait_cyc(1); rd(2'd0, v); check("R4 reload", v, 8'hFD); check("R4 irq pulse", irq, 1);
    wait_cyc(1); check("R4 irq single", irq, 0);

    // R6 / R9: on but mode 00 holds, reload write deferred
    wr(2'd2, 8'h10);
    rd(2'd0, c0);
    wr(2'd1, 8'h33);
    rd(2'd0, v); check("R6 counter kept", v, c0);
    rd(2'd1, v); check("R6 reload stored", v, 8'h33);
    wait_cyc(10); rd(2'd0, v); check("R9 mode00 hold", v, c0);
    wr(2'd2, 8'h90); wait_cyc(300);
    wr(2'd2, 8'h80); rd(2'd0, c0); wait_cyc(20); rd(2'd0, v); check("R9 run0 hold", v, c0);

    // R3 prescaler 1:8
    wr(2'd2, 8'h00); wr(2'd1, 8'h00);
    wr(2'd2, 8'h93);
    wait_cyc(7); rd(2'd0, v); check("R3 before tick", v, 0);
    wait_cyc(1); rd(2'd0, v); check("R3 first tick", v, 1);
    wait_cyc(64); rd(2'd0, v); check("R3 after 64", v, 9);
    wr(2'd2, 8'h97); wait_cyc(600);

    // R7 event rising, prescale field set to show it is ignored
    wr(2'd2, 8'h00); wr(2'd1, 8'hF0); wr(2'd2, 8'h57);
    reg_addr = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk) tmr_pin = 1;
      wait_cyc(2); rd(2'd0, v); check("R7 latency hold", v, 8'hF0 + (i % 16));
      wait_cyc(1); rd(2'd0, v); check("R7 rise step", v, (i == 15) ? 8'hF0 : 8'hF0 + ((i + 1) % 16));
      @(negedge clk) tmr_pin = 0; wait_cyc(3);
    end
    // R7 falling
    wr(2'd2, 8'h00); wr(2'd1, 8'h20); wr(2'd2, 8'h58);
    @(negedge clk) tmr_pin = 1; wait_cyc(4); rd(2'd0, v); check("R7 rise ignored", v, 8'h20);
    @(negedge clk) tmr_pin = 0; wait_cyc(3); rd(2'd0, v); check("R7 fall step", v, 8'h21);

    // R8 pulse width active high, 1:2
    wr(2'd2, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'hD1);
    wait_cyc(6); rd(2'd0, v); check("R8 idle low no count", v, 0);
    @(negedge clk) tmr_pin = 1; wait_cyc(40);
    @(negedge clk) tmr_pin = 0; wait_cyc(4);
    rd(2'd2, v); check("R8 run cleared", v, 8'hC1);
    rd(2'd0, c0); wait_cyc(10); rd(2'd0, v); check("R8 frozen", v, c0);
    // R8 active low
    wr(2'd1, 8'h00); @(negedge clk) tmr_pin = 1; wr(2'd2, 8'hD8); wait_cyc(4);
    @(negedge clk) tmr_pin = 0; wait_cyc(30);
    @(negedge clk) tmr_pin = 1; wait_cyc(4);
    rd(2'd2, v); check("R8 low run cleared", v, 8'hC8);

    // R10 control write collides with pulse-end clear
    tmr_pin = 0; wr(2'd2, 8'h00); wr(2'd2, 8'hD0);
    @(negedge clk) tmr_pin = 1; wait_cyc(10);
    @(negedge clk) tmr_pin = 0;
    @(negedge clk);
    wr(2'd2, 8'hD1);
    rd(2'd2, v); check("R10 write wins", v, 8'hD1);
    wait_cyc(5);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule